// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block sits next to a small 8-bit microcontroller core and decides when the core must break off its program to run an interrupt handler. It watches the raw request lines, and a rising edge on any line sets a pending flag for that source. A global enable and a per-source enable, both held in byte-wide registers on a simple register port, mask the flags. The block then picks a winner among the enabled, pending sources. Each source has a one-bit priority level. Within a level, a fixed order of sources breaks ties.

The decision is taken only at an instruction boundary that the core signals. When a source wins, the controller raises a call request and presents the handler address. It holds both until the core acknowledges. A two-bit in-service register remembers which levels are running handlers, so only a strictly higher level can interrupt a handler. The core's return-from-interrupt strobe pops the highest running level. A boundary in which the core is returning from an interrupt, or writing one of the controller's registers, takes no decision.

The controller is a two-state machine. `S_POLL` waits for a boundary, and the transition *take* moves it to `S_CALL` when a source may be granted. `S_CALL` drives the request, and the transition *ack* returns it to `S_POLL` while the flag is cleared and the in-service bit is set.

Top module: `irq_nest_ctrl`

## Requirements
- R1: A rising edge on `src_in[i]` sets the pending flag of source i whether or not that source or the global enable is set. The flag stays set until it is cleared as stated in R9.
- R2: A source can win only if its flag is set, its enable bit is 1, and the global enable (register 0, bit 7) is 1. Register 0 holds the enables for source indices 0 to 4 in bits 0 to 4. Register 1 holds the enables for source indices 5 to 9 in bits 0 to 4.
- R3: Arbitration happens only in a cycle where `insn_bnd` is 1. `call_req` rises on the clock edge that samples that cycle. It then stays 1, with `call_vec` unchanged, until the cycle in which `call_ack` is 1, and falls on the edge that samples the acknowledge.
- R4: The source indices run in this order: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 to 9 extra externals 2 to 6. The vector is 0x0003 + 8 × index, which gives 0x0003, 0x000B, 0x0013, 0x001B, 0x0023 and so on up to 0x004B.
- R5: The level of source i is bit i of register 3 for i < 8, and bit i−8 of register 4 for i ≥ 8. A value of 1 means the high level. A candidate at the high level beats any candidate at the low level. Within a level, the lowest index wins.
- R6: An acknowledge sets the in-service bit of the granted level. A candidate is granted only if its level is strictly above every level in service. A low request waits while either level is in service, and a high request waits while the high level is in service.
- R7: A pulse on `reti_exec` clears the highest set in-service bit. Once the high level's handler has returned, a still-running low level continues to block low requests.
- R8: A boundary in which `reti_exec` or `sfr_wr` is 1 takes no decision, and `call_req` stays 0 after that edge.
- R9: An acknowledge clears the flag of the granted source, except the serial source (index 4). The serial flag stays set until `ser_clr` is pulsed.
- R10: Registers 0 to 4 are eight bits wide, reset to 0, and read back exactly what was last written. Bits that control nothing, such as bit 6 of register 0, are plain storage and have no effect on requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 10 | Raw request lines; a rising edge sets the flag |
| ser_clr | input | 1 | Clears the serial flag |
| insn_bnd | input | 1 | Core is at an instruction boundary |
| reti_exec | input | 1 | Core is executing a return from interrupt |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 3 | Register select (0..4) for read and write |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data for `sfr_addr` |
| call_req | output | 1 | Forced call request to the core |
| call_vec | output | 16 | Handler address of the granted source |
| call_ack | input | 1 | Core accepts the call |

## Verification
The bench builds the block with its defaults: five extra external sources (ten in all), 16-bit vectors, a base of 0x0003 and a step of 8. Ten sources bring the highest vector, 0x004B, within reach. They also reach the second priority register, so a source that draws its level from register 4 can be shown beating a low-index source that sits at the low level. The nesting sequence takes the in-service register through 01, 11 and 01 back to 00. This shows equal-level blocking, strictly-higher preemption, and the pop order of return-from-interrupt.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    typedef enum logic [0:0] {
        S_POLL = 1'b0,
        S_CALL = 1'b1
    } irq_state_t;

    localparam int BASE_SRC = 5;
    localparam int SER_IDX  = 4;
    localparam int NREG     = 5;
    localparam int RW       = 8;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N       = 10,
    parameter int SER_POS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_in,
    input  logic [N-1:0] ack_clr,
    input  logic         ser_clr,
    output logic [N-1:0] flags
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= src_in;
    end

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic rise;
        logic drop;
        assign rise = src_in[i] & ~prev_q[i];
        if (i == SER_POS) begin : g_ser
            assign drop = ser_clr;
        end else begin : g_auto
            assign drop = ack_clr[i];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= rise | (flags[i] & ~drop);
        end
    end

endmodule

// File: rtl/irq_sfr_regs.sv
module irq_sfr_regs
    import irq_nest_pkg::*;
#(
    parameter int N = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [2:0]    addr,
    input  logic [RW-1:0] wdata,
    output logic [RW-1:0] rdata,
    output logic [N-1:0]  en_vec,
    output logic          glob_en,
    output logic [N-1:0]  pri_vec
);

    localparam int NX = N - BASE_SRC;

    logic [RW-1:0] regs_q [NREG];
    logic [2*RW-1:0] pri_word;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                        regs_q[r] <= '0;
            else if (wr && addr == 3'(r))      regs_q[r] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(addr) < NREG) rdata = regs_q[addr];
    end

    assign glob_en  = regs_q[0][7];
    assign en_vec   = {regs_q[1][NX-1:0], regs_q[0][BASE_SRC-1:0]};
    assign pri_word = {regs_q[4], regs_q[3]};
    assign pri_vec  = pri_word[N-1:0];

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int N  = 10,
    parameter int IW = 4
) (
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  pri,
    input  logic [1:0]    isr,
    output logic          valid,
    output logic [IW-1:0] idx,
    output logic          lvl
);

    logic         hi_ok;
    logic         lo_ok;
    logic [N-1:0] cand_hi;
    logic [N-1:0] cand_lo;
    logic [N-1:0] sel;

    always_comb begin
        hi_ok   = ~isr[1];
        lo_ok   = (isr == 2'b00);
        cand_hi = pend & pri & {N{hi_ok}};
        cand_lo = pend & ~pri & {N{lo_ok}};
        lvl     = |cand_hi;
        sel     = lvl ? cand_hi : cand_lo;
        valid   = |sel;
        idx     = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (sel[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/irq_inservice.sv
module irq_inservice (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_en,
    input  logic       set_lvl,
    input  logic       reti,
    output logic [1:0] isr
);

    logic [1:0] nxt;

    always_comb begin
        nxt = isr;
        if (reti) begin
            if (nxt[1]) nxt[1] = 1'b0;
            else        nxt[0] = 1'b0;
        end
        if (set_en) nxt[set_lvl] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) isr <= 2'b00;
        else        isr <= nxt;
    end

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int NX       = 5,
    parameter int VW       = 16,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BASE_SRC+NX-1:0] src_in,
    input  logic                  ser_clr,
    input  logic                  insn_bnd,
    input  logic                  reti_exec,
    input  logic                  sfr_wr,
    input  logic [2:0]            sfr_addr,
    input  logic [7:0]            sfr_wdata,
    output logic [7:0]            sfr_rdata,
    output logic                  call_req,
    output logic [VW-1:0]         call_vec,
    input  logic                  call_ack
);

    localparam int NSRC = BASE_SRC + NX;
    localparam int IW   = $clog2(NSRC);

    irq_state_t     state_q;
    logic [IW-1:0]  win_idx_q;
    logic           win_lvl_q;

    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] en_vec;
    logic [NSRC-1:0] pri_vec;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] clr_vec;
    logic            glob_en;
    logic            arb_valid;
    logic [IW-1:0]   arb_idx;
    logic            arb_lvl;
    logic [1:0]      isr_q;
    logic            take;
    logic            ack_fire;

    irq_flag_bank #(.N(NSRC), .SER_POS(SER_IDX)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_in  (src_in),
        .ack_clr (clr_vec),
        .ser_clr (ser_clr),
        .flags   (flags)
    );

    irq_sfr_regs #(.N(NSRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (sfr_wr),
        .addr    (sfr_addr),
        .wdata   (sfr_wdata),
        .rdata   (sfr_rdata),
        .en_vec  (en_vec),
        .glob_en (glob_en),
        .pri_vec (pri_vec)
    );

    assign pend = flags & en_vec & {NSRC{glob_en}};

    irq_arbiter #(.N(NSRC), .IW(IW)) u_arb (
        .pend  (pend),
        .pri   (pri_vec),
        .isr   (isr_q),
        .valid (arb_valid),
        .idx   (arb_idx),
        .lvl   (arb_lvl)
    );

    irq_inservice u_isr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (ack_fire),
        .set_lvl (win_lvl_q),
        .reti    (reti_exec),
        .isr     (isr_q)
    );

    assign take = insn_bnd && !reti_exec && !sfr_wr && arb_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_POLL;
            win_idx_q <= '0;
            win_lvl_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_POLL: begin
                    if (take) begin
                        state_q   <= S_CALL;
                        win_idx_q <= arb_idx;
                        win_lvl_q <= arb_lvl;
                    end
                end
                S_CALL: begin
                    if (call_ack) state_q <= S_POLL;
                end
                default: state_q <= S_POLL;
            endcase
        end
    end

    always_comb begin
        call_req = 1'b0;
        ack_fire = 1'b0;
        clr_vec  = '0;
        call_vec = VW'(VEC_BASE + int'(win_idx_q) * VEC_STEP);
        unique case (state_q)
            S_POLL: call_req = 1'b0;
            S_CALL: begin
                call_req = 1'b1;
                ack_fire = call_ack;
                if (call_ack) clr_vec = NSRC'(1) << win_idx_q;
            end
            default: call_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
    parameter int VW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          insn_bnd,
    input logic          reti_exec,
    input logic          sfr_wr,
    input logic          call_req,
    input logic          call_ack,
    input logic [VW-1:0] call_vec,
    input logic          glob_en,
    input logic [1:0]    isr
);

    a_r3_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        call_req && !call_ack |=> call_req);

    a_r3_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
        call_req && !call_ack |=> $stable(call_vec));

    a_r3_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !call_req && !insn_bnd |=> !call_req);

    a_r3_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        call_req && call_ack |=> !call_req);

    a_r8_blocked_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !call_req && (reti_exec || sfr_wr) |=> !call_req);

    a_r2_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        !call_req && !glob_en |=> !call_req);

    a_r6_ack_marks_level: assert property (@(posedge clk) disable iff (!rst_n)
        call_req && call_ack && !reti_exec |=> isr != 2'b00);

endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.VW(VW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_bnd  (insn_bnd),
    .reti_exec (reti_exec),
    .sfr_wr    (sfr_wr),
    .call_req  (call_req),
    .call_ack  (call_ack),
    .call_vec  (call_vec),
    .glob_en   (glob_en),
    .isr       (isr_q)
);

// File: tb/irq_nest_ctrl_test.sv
module irq_nest_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  src_in;
    logic        ser_clr;
    logic        insn_bnd;
    logic        reti_exec;
    logic        sfr_wr;
    logic [2:0]  sfr_addr;
    logic [7:0]  sfr_wdata;
    logic [7:0]  sfr_rdata;
    logic        call_req;
    logic [15:0] call_vec;
    logic        call_ack;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_nest_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .ser_clr   (ser_clr),
        .insn_bnd  (insn_bnd),
        .reti_exec (reti_exec),
        .sfr_wr    (sfr_wr),
        .sfr_addr  (sfr_addr),
        .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata),
        .call_req  (call_req),
        .call_vec  (call_vec),
        .call_ack  (call_ack)
    );

    // row: src, en0, en1, pri0, pri1, expected request, expected vector
    localparam logic [58:0] TBL [8] = '{
        {10'h001, 8'h81, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0003},
        {10'h3FF, 8'h9F, 8'h1F, 8'h00, 8'h00, 1'b1, 16'h0003},
        {10'h3FF, 8'h9F, 8'h1F, 8'h10, 8'h00, 1'b1, 16'h0023},
        {10'h200, 8'h80, 8'h10, 8'h00, 8'h00, 1'b1, 16'h004B},
        {10'h006, 8'h84, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0013},
        {10'h0FF, 8'h1F, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000},
        {10'h300, 8'h80, 8'h18, 8'h00, 8'h02, 1'b1, 16'h004B},
        {10'h022, 8'h82, 8'h01, 8'h20, 8'h00, 1'b1, 16'h002B}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src_in = '0; ser_clr = 1'b0; insn_bnd = 1'b0;
        reti_exec = 1'b0; sfr_wr = 1'b0; sfr_addr = '0; sfr_wdata = '0; call_ack = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic pulse_src(input logic [9:0] m);
        @(negedge clk);
        src_in = m;
        @(negedge clk);
        src_in = '0;
    endtask

    task automatic boundary(input logic with_reti, input logic with_wr);
        @(negedge clk);
        insn_bnd = 1'b1; reti_exec = with_reti;
        if (with_wr) begin
            sfr_wr = 1'b1; sfr_addr = 3'd2; sfr_wdata = 8'h00;
        end
        @(negedge clk);
        insn_bnd = 1'b0; reti_exec = 1'b0; sfr_wr = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        call_ack = 1'b1;
        @(negedge clk);
        call_ack = 1'b0;
    endtask

    task automatic reti();
        @(negedge clk);
        reti_exec = 1'b1;
        @(negedge clk);
        reti_exec = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // reset state
        chk("R3 reset call_req", 32'(call_req), 32'd0);
        for (int a = 0; a < 5; a++) begin
            sfr_addr = 3'(a);
            #1;
            chk("R10 reset register value", 32'(sfr_rdata), 32'd0);
        end

        // table of source, enable and priority patterns (R2 R4 R5)
        for (int r = 0; r < 8; r++) begin
            do_reset();
            wr(3'd0, TBL[r][48:41]);
            wr(3'd1, TBL[r][40:33]);
            wr(3'd3, TBL[r][32:25]);
            wr(3'd4, TBL[r][24:17]);
            pulse_src(TBL[r][58:49]);
            boundary(1'b0, 1'b0);
            chk("R2 table request", 32'(call_req), 32'(TBL[r][16]));
            if (TBL[r][16]) chk("R4 R5 table vector", 32'(call_vec), 32'(TBL[r][15:0]));
        end

        // R1: flag latched while disabled
        do_reset();
        pulse_src(10'h001);
        wr(3'd0, 8'h81);
        boundary(1'b0, 1'b0);
        chk("R1 flag kept while disabled", 32'(call_req), 32'd1);
        chk("R1 vector", 32'(call_vec), 32'h0003);

        // R10: plain storage bit
        do_reset();
        wr(3'd0, 8'h41);
        sfr_addr = 3'd0;
        #1;
        chk("R10 readback", 32'(sfr_rdata), 32'h41);
        wr(3'd4, 8'hA5);
        sfr_addr = 3'd4;
        #1;
        chk("R10 readback reg4", 32'(sfr_rdata), 32'hA5);
        pulse_src(10'h001);
        boundary(1'b0, 1'b0);
        chk("R10 storage bit no effect", 32'(call_req), 32'd0);

        // R8: blocking rules
        do_reset();
        wr(3'd0, 8'h81);
        pulse_src(10'h001);
        boundary(1'b1, 1'b0);
        chk("R8 reti blocks", 32'(call_req), 32'd0);
        boundary(1'b0, 1'b1);
        chk("R8 register write blocks", 32'(call_req), 32'd0);
        boundary(1'b0, 1'b0);
        chk("R8 plain boundary grants", 32'(call_req), 32'd1);

        // R3: hold and boundary requirement
        do_reset();
        wr(3'd0, 8'h81);
        pulse_src(10'h001);
        repeat (2) @(negedge clk);
        chk("R3 no request without boundary", 32'(call_req), 32'd0);
        boundary(1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R3 request held", 32'(call_req), 32'd1);
        chk("R3 vector held", 32'(call_vec), 32'h0003);
        ack();
        chk("R3 request drops on ack", 32'(call_req), 32'd0);

        // R6 R7: nesting
        do_reset();
        wr(3'd0, 8'h9F);
        wr(3'd3, 8'h04);
        pulse_src(10'h002);
        boundary(1'b0, 1'b0);
        chk("R6 low grant", 32'(call_vec), 32'h000B);
        ack();
        pulse_src(10'h001);
        boundary(1'b0, 1'b0);
        chk("R6 equal level waits", 32'(call_req), 32'd0);
        pulse_src(10'h004);
        boundary(1'b0, 1'b0);
        chk("R6 higher level preempts", 32'(call_req), 32'd1);
        chk("R6 preempt vector", 32'(call_vec), 32'h0013);
        ack();
        boundary(1'b0, 1'b0);
        chk("R6 both levels busy", 32'(call_req), 32'd0);
        reti();
        boundary(1'b0, 1'b0);
        chk("R7 low still in service", 32'(call_req), 32'd0);
        reti();
        boundary(1'b0, 1'b0);
        chk("R7 resumes after last return", 32'(call_req), 32'd1);
        chk("R7 vector", 32'(call_vec), 32'h0003);
        ack();
        reti();

        // R9: flag clearing
        boundary(1'b0, 1'b0);
        chk("R9 auto cleared flags", 32'(call_req), 32'd0);
        wr(3'd0, 8'h90);
        pulse_src(10'h010);
        boundary(1'b0, 1'b0);
        chk("R9 serial grant", 32'(call_vec), 32'h0023);
        ack();
        reti();
        boundary(1'b0, 1'b0);
        chk("R9 serial flag kept", 32'(call_req), 32'd1);
        ack();
        reti();
        @(negedge clk);
        ser_clr = 1'b1;
        @(negedge clk);
        ser_clr = 1'b0;
        boundary(1'b0, 1'b0);
        chk("R9 serial flag cleared", 32'(call_req), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule